// File: doc/BRIEF.md
# Addressable LED Pulse-Train Encoder

This block turns a stream of 24-bit pixel words into the single-wire pulse train that daisy-chained RGB LEDs expect. Each pixel bit becomes eight fixed-length output slots whose levels come from one of two byte-wide patterns: a short-high pattern for a zero and a longer-high pattern for a one. Slots are paced by a strobe divided down from the system clock. With the default divider setting and a 100 MHz system clock, each slot lasts 250 ns (4 MHz). The two patterns, the divider ratio and the length of the end-of-frame latch period are parameters.

Pixels arrive on a valid/ready stream with a flag that marks the last pixel of a frame. A pixel is taken only on a slot strobe at which it can be started with no gap after the previous bit. After the final slot of the last pixel, the block holds the line at its inactive level for a programmable number of slots, so the chain latches the frame. A static polarity input complements every level on the line, including idle and latch levels, so the output can drive an inverting level shifter. The busy output covers the whole frame, from the first pixel accepted to the end of the latch period.

Top module: `led_wave_enc`

## Requirements
- R1: While reset is asserted, `busy` and `in_ready` are low and `data_out` equals `inv_en`, which is the inactive level.
- R2: The line level changes only on slot strobes. A strobe occurs every `CLK_PER_SLOT` system clocks, counted from the release of the internal reset.
- R3: A pixel bit of value 0 is emitted as the 8 slots of `ZERO_PAT` (default 8'h40), taking the pattern's bit 7 first and bit 0 last. A pattern bit of 1 is the active level.
- R4: A pixel bit of value 1 is emitted as the 8 slots of `ONE_PAT` (default 8'h70), taking the pattern's bit 7 first and bit 0 last.
- R5: The bits of a pixel word are sent from bit 23 down to bit 0. Pixels are sent in the order they are accepted.
- R6: When `inv_en` is 1, every level on `data_out` is complemented. This includes the pattern slots, the idle level and the latch level. The default patterns then appear as 8'hBF and 8'h8F.
- R7: `in_ready` is high only on a slot strobe, and only in one of three situations: no frame is open, an open frame is waiting for its next pixel, or the final slot of a non-last pixel is being emitted. A pixel accepted on the final slot of the previous pixel starts on the very next slot.
- R8: After the final slot of a pixel flagged `in_last`, the line stays inactive for exactly `RESET_SLOTS` slots (default 40, which is 10 us at 4 MHz). `in_ready` stays low during this period.
- R9: `busy` rises on the clock after the first pixel of a frame is accepted. It stays high through gaps between pixels and falls on the clock after the last latch slot.
- R10: Inside an open frame with no pixel pending, the line sits at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inv_en | input | 1 | Complements every output level; change only while `busy` is low |
| in_valid | input | 1 | A pixel word is offered |
| in_pixel | input | PIX_W | Pixel word, sent from its top bit down |
| in_last | input | 1 | The offered pixel ends the frame |
| in_ready | output | 1 | The offered pixel is taken on this clock |
| data_out | output | 1 | Encoded serial LED line |
| busy | output | 1 | A frame or its latch period is in progress |

## Verification
The pulse train is compared slot by slot against a queue-based model for pixel words that mix ones and zeros (0xA50F3C, 0xC3C3C3), for words that are nearly all zeros or nearly all ones with the odd bit at the far end (0x000001, 0xFFFFFE, 0x800000), and for an all-zero word. These words separate the two patterns from each other and expose any reversal of bit order or slot order. Pixels sent back to back test the zero-gap handover. A long pause inside a frame tests the idle level and the continuation of busy. Frames sent with inversion on and off test that the active level, the idle level and the latch level are all complemented. A frame that starts as soon as a latch period ends tests the exact latch length.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_DATA,
    ST_LATCH
  } enc_state_t;

endpackage

// File: rtl/led_slot_div.sv
module led_slot_div #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/led_slot_pick.sv
module led_slot_pick #(
  parameter int          SLOT_N   = 8,
  parameter logic [7:0]  ZERO_PAT = 8'h40,
  parameter logic [7:0]  ONE_PAT  = 8'h70,
  localparam int         SW       = $clog2(SLOT_N)
) (
  input  logic          bit_val,
  input  logic [SW-1:0] slot,
  output logic          level
);

  logic [SW-1:0] ridx;

  always_comb begin
    ridx  = SW'(SLOT_N - 1) - slot;
    level = bit_val ? ONE_PAT[ridx] : ZERO_PAT[ridx];
  end

endmodule

// File: rtl/led_wave_enc.sv
module led_wave_enc
  import led_enc_pkg::*;
#(
  parameter int         CLK_PER_SLOT = 25,
  parameter int         PIX_W        = 24,
  parameter logic [7:0] ZERO_PAT     = 8'h40,
  parameter logic [7:0] ONE_PAT      = 8'h70,
  parameter int         RESET_SLOTS  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_en,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             in_last,
  output logic             in_ready,
  output logic             data_out,
  output logic             busy
);

  localparam int SLOT_N = 8;
  localparam int SLOT_W = $clog2(SLOT_N);
  localparam int BIT_W  = $clog2(PIX_W);
  localparam int RC_W   = $clog2(RESET_SLOTS + 1);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SLOT_N - 1);
  localparam logic [BIT_W-1:0]  BIT_END  = BIT_W'(PIX_W - 1);
  localparam logic [RC_W-1:0]   RC_END   = RC_W'(RESET_SLOTS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic tick;

  led_slot_div #(.DIV(CLK_PER_SLOT)) u_div (
    .clk  (clk),
    .rst_n(rst_i),
    .tick (tick)
  );

  enc_state_t        state_q, state_d;
  logic [PIX_W-1:0]  sr_q, sr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [RC_W-1:0]   rc_q, rc_d;
  logic              last_q, last_d;
  logic              line_q, line_d;
  logic              lvl;
  logic              end_pix;
  logic              acc;

  led_slot_pick #(
    .SLOT_N  (SLOT_N),
    .ZERO_PAT(ZERO_PAT),
    .ONE_PAT (ONE_PAT)
  ) u_pick (
    .bit_val(sr_q[PIX_W-1]),
    .slot   (slot_q),
    .level  (lvl)
  );

  assign end_pix  = (slot_q == SLOT_END) && (bit_q == BIT_END);
  assign in_ready = tick && ((state_q == ST_IDLE) || (state_q == ST_GAP) ||
                             ((state_q == ST_DATA) && end_pix && !last_q));
  assign acc      = in_valid && in_ready;
  assign busy     = (state_q != ST_IDLE);
  assign data_out = line_q ^ inv_en;

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    bit_d   = bit_q;
    slot_d  = slot_q;
    rc_d    = rc_q;
    last_d  = last_q;
    line_d  = line_q;
    if (tick) begin
      case (state_q)
        ST_IDLE, ST_GAP: begin
          line_d = 1'b0;
          if (acc) begin
            sr_d    = in_pixel;
            last_d  = in_last;
            bit_d   = '0;
            slot_d  = '0;
            state_d = ST_DATA;
          end
        end
        ST_DATA: begin
          line_d = lvl;
          if (slot_q == SLOT_END) begin
            slot_d = '0;
            if (bit_q == BIT_END) begin
              bit_d = '0;
              if (acc) begin
                sr_d   = in_pixel;
                last_d = in_last;
              end else if (last_q) begin
                rc_d    = '0;
                state_d = ST_LATCH;
              end else begin
                state_d = ST_GAP;
              end
            end else begin
              bit_d = bit_q + BIT_W'(1);
              sr_d  = {sr_q[PIX_W-2:0], 1'b0};
            end
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end
        default: begin
          line_d = 1'b0;
          if (rc_q == RC_END) state_d = ST_IDLE;
          else                rc_d    = rc_q + RC_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      bit_q   <= '0;
      slot_q  <= '0;
      rc_q    <= '0;
      last_q  <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      bit_q   <= bit_d;
      slot_q  <= slot_d;
      rc_q    <= rc_d;
      last_q  <= last_d;
      line_q  <= line_d;
    end
  end

endmodule

// File: rtl/led_wave_enc_chk.sv
module led_wave_enc_chk
  import led_enc_pkg::*;
(
  input logic       clk,
  input logic       rst_i,
  input logic       tick,
  input logic       in_valid,
  input logic       in_ready,
  input logic       busy,
  input logic       line_q,
  input enc_state_t state_q
);

  // R7
  ready_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_i)
    in_ready |-> tick);

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !tick |=> $stable(line_q));

  // R8
  latch_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_LATCH) |-> !in_ready);

  // R8
  busy_end_latch_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(busy) |-> ($past(state_q) == ST_LATCH));

  // R9
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_ready) |=> busy);

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_GAP || !busy) |-> !line_q);

endmodule

bind led_wave_enc led_wave_enc_chk u_chk (
  .clk     (clk),
  .rst_i   (rst_i),
  .tick    (tick),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .busy    (busy),
  .line_q  (line_q),
  .state_q (state_q)
);

// File: tb/led_wave_enc_test.sv
`timescale 1ns/1ps
module led_wave_enc_test;

  localparam int DIV  = 3;
  localparam int PW   = 24;
  localparam int RSL  = 40;
  localparam logic [7:0] ZP = 8'h40;
  localparam logic [7:0] OP = 8'h70;

  logic clk = 1'b0;
  logic rst_n;
  logic inv_en;
  logic in_valid;
  logic [PW-1:0] in_pixel;
  logic in_last;
  logic in_ready;
  logic data_out;
  logic busy;

  always #2 clk = ~clk;

  led_wave_enc #(
    .CLK_PER_SLOT(DIV),
    .PIX_W       (PW),
    .ZERO_PAT    (ZP),
    .ONE_PAT     (OP),
    .RESET_SLOTS (RSL)
  ) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .inv_en  (inv_en),
    .in_valid(in_valid),
    .in_pixel(in_pixel),
    .in_last (in_last),
    .in_ready(in_ready),
    .data_out(data_out),
    .busy    (busy)
  );

  int n_chk = 0;
  int n_bad = 0;

  // model state: 0/1 = pattern slot level, 2 = latch slot
  int   q[$];
  int   tcnt = 0;
  logic exp_raw = 1'b0;
  logic exp_busy = 1'b0;
  logic frame_open = 1'b0;
  logic accepted;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: check ready, update model for next edge, check outputs after it
  task automatic step();
    logic tk, rdy;
    int v;
    #1;
    tk  = (tcnt == DIV - 1);
    rdy = tk && (q.size() == 0 || (q.size() == 1 && q[0] != 2));
    chk(in_ready == rdy, "R7 R8 ready", int'(in_ready), int'(rdy));
    accepted = in_valid && rdy;
    if (tk) begin
      if (q.size() > 0) begin
        v = q.pop_front();
        exp_raw = (v == 1);
      end else begin
        exp_raw = 1'b0;
      end
      if (accepted) begin
        for (int b = PW - 1; b >= 0; b--) begin
          for (int s = 0; s < 8; s++) begin
            q.push_back(in_pixel[b] ? int'(OP[7-s]) : int'(ZP[7-s]));
          end
        end
        if (in_last) begin
          for (int r = 0; r < RSL; r++) q.push_back(2);
        end
        frame_open = !in_last;
      end
    end
    tcnt = tk ? 0 : tcnt + 1;
    exp_busy = frame_open || (q.size() > 0);
    @(negedge clk);
    chk(data_out == (exp_raw ^ inv_en), "R2 R3 R4 R5 R6 R8 R10 line",
        int'(data_out), int'(exp_raw ^ inv_en));
    chk(busy == exp_busy, "R9 busy", int'(busy), int'(exp_busy));
  endtask

  task automatic send(input logic [PW-1:0] pix, input logic lst, input int gap);
    for (int g = 0; g < gap; g++) step();
    in_valid = 1'b1;
    in_pixel = pix;
    in_last  = lst;
    accepted = 1'b0;
    while (!accepted) step();
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0 || frame_open) step();
    for (int k = 0; k < 4; k++) step();
  endtask

  initial begin
    rst_n    = 1'b0;
    inv_en   = 1'b0;
    in_valid = 1'b0;
    in_pixel = '0;
    in_last  = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state, both polarities
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(in_ready == 1'b0, "R1 ready", int'(in_ready), 0);
    chk(data_out == 1'b0, "R1 line", int'(data_out), 0);
    inv_en = 1'b1;
    #1;
    chk(data_out == 1'b1, "R1 R6 line inverted", int'(data_out), 1);
    inv_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);

    // R3 R4 R5 R7: back-to-back pixels, then latch (R8)
    send(24'hA50F3C, 1'b0, 0);
    send(24'h000001, 1'b0, 0);
    send(24'hFFFFFE, 1'b1, 0);
    drain();

    // R9 R10: pause inside a frame
    send(24'h800000, 1'b0, 5);
    send(24'h123456, 1'b1, 700);
    drain();

    // R6: inverted output, frame starting right after a latch (R8)
    inv_en = 1'b1;
    send(24'hC3C3C3, 1'b1, 2);
    send(24'h000000, 1'b1, 0);
    drain();
    inv_en = 1'b0;
    send(24'h5A5A5A, 1'b1, 1);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule